// File: doc/BRIEF.md
# Timed Arm-and-Fire Command Sequencer

This block turns slow discrete commands from a host computer into the enables for a deployment mechanism. It drives one arming relay and a set of initiator channels. Each command input is synchronised, then sampled once per millisecond, and a new level is accepted only when two samples in a row agree. A filtered rising edge of the arm command opens an armed window of fixed length, and the relay enable is on for that whole window. A rising edge on a channel's fire command inside the window starts a fixed-length pulse on that channel. One heater channel has no pulse timer: its output follows its command level while the window is open.

When the window runs out, the relay enable drops and every channel output is forced off in the same cycle. To hold the window open longer, the host drops the arm command and then raises it again. This restarts the window from zero. All timing counts a millisecond tick that a prescaler derives from the system clock. An asynchronous active-low reset holds every output low.

Top module: `arm_fire_seq`

## Requirements
- R1: While rst_ni is low, arm_relay_o, fire_en_o and heat_en_o are all 0, whatever the command inputs do.
- R2: A command level that lasts less than one millisecond tick period is never accepted. A level held for two consecutive tick samples is accepted.
- R3: A filtered rising edge of arm_cmd_i sets arm_relay_o for ARM_MS ticks, from 1 to about 2 ms after the edge. Holding arm_cmd_i high does not extend the window.
- R4: A fire command edge while arm_relay_o is 0 is ignored, and no fire_en_o bit rises at any time without arm_relay_o high.
- R5: A fire pulse lasts PULSE_MS ticks and then ends, even if its command stays high. A pulse ends only on a tick cycle or when the window closes.
- R6: Each bit of fire_en_o (bit i is driven by fire_cmd_i[i]) has its own timer. Pulses on different channels overlap without affecting each other.
- R7: Dropping arm_cmd_i and raising it again while armed restarts the window, which then lasts ARM_MS ticks from the new edge.
- R8: heat_en_o equals the filtered heat_cmd_i level while armed and is 0 when not armed. It has no pulse limit.
- R9: When the window expires, arm_relay_o, every fire_en_o bit and heat_en_o go low in the same cycle.
- R10: A channel fires only on a rising edge seen while the window is already open. A fire command that was high before the window opened, or that rises in the same filtered tick as the arm edge, does nothing until it is dropped and raised again.
- R11: One millisecond tick is CLK_PER_MS clock cycles, and every duration above is counted in these ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| arm_cmd_i | input | 1 | Raw arm discrete command |
| fire_cmd_i | input | N_FIRE | Raw fire discrete commands, one per pulsed channel |
| heat_cmd_i | input | 1 | Raw heater discrete command |
| arm_relay_o | output | 1 | Arming relay enable, high for the armed window |
| fire_en_o | output | N_FIRE | Pulsed initiator channel enables |
| heat_en_o | output | 1 | Level-held heater channel enable |

## Verification
Two pairs of events can fall in the same cycle. The first pair is window expiry and a running fire pulse. The bench fires a channel a few milliseconds before expiry, so the pulse would outlast the window, and holds the heater on as well. It then checks that the relay, the pulse and the heater are all low just after expiry. The second pair is the arm edge and a fire edge. The bench raises both commands at the same instant, so both pass through the filter on the same tick. It then checks that the channel stays off for the whole window until its command is raised again.

// File: rtl/afs_pkg.sv
package afs_pkg;
  typedef enum logic {CH_IDLE = 1'b0, CH_FIRING = 1'b1} ch_state_e;

  function automatic int unsigned cnt_w(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/afs_ms_tick.sv
module afs_ms_tick #(
  parameter int unsigned CLK_PER_MS = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = afs_pkg::cnt_w(CLK_PER_MS - 1);
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_MS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (cnt_q == LAST);
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/afs_cmd_filter.sv
module afs_cmd_filter #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] filt_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic s1_q, s2_q, samp_q, filt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        samp_q <= 1'b0;
        filt_q <= 1'b0;
      end else begin
        s1_q <= raw_i[b];
        s2_q <= s1_q;
        if (tick_i) begin
          samp_q <= s2_q;
          // accept only when this sample matches the previous one
          if (s2_q == samp_q) filt_q <= s2_q;
        end
      end
    end
    assign filt_o[b] = filt_q;
  end
endmodule

// File: rtl/afs_arm_window.sv
module afs_arm_window #(
  parameter int unsigned ARM_MS = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic arm_i,
  output logic armed_o
);
  localparam int unsigned CW = afs_pkg::cnt_w(ARM_MS);

  logic          arm_q;
  logic [CW-1:0] left_q;
  logic          arm_edge;

  assign arm_edge = arm_i & ~arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q   <= 1'b0;
      armed_o <= 1'b0;
      left_q  <= '0;
    end else begin
      arm_q <= arm_i;
      if (arm_edge) begin
        armed_o <= 1'b1;
        left_q  <= CW'(ARM_MS);
      end else if (armed_o && tick_i) begin
        if (left_q == CW'(1)) armed_o <= 1'b0;
        else                  left_q  <= left_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/afs_pulse_timer.sv
module afs_pulse_timer #(
  parameter int unsigned PULSE_MS = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic armed_i,
  input  logic req_i,
  output logic en_o
);
  import afs_pkg::*;
  localparam int unsigned CW = cnt_w(PULSE_MS);

  ch_state_e     st_q;
  logic          req_q;
  logic [CW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= CH_IDLE;
      req_q  <= 1'b0;
      left_q <= '0;
    end else begin
      req_q <= req_i;
      if (!armed_i) begin
        st_q <= CH_IDLE;
      end else begin
        case (st_q)
          CH_IDLE: if (req_i && !req_q) begin
            st_q   <= CH_FIRING;
            left_q <= CW'(PULSE_MS);
          end
          CH_FIRING: if (tick_i) begin
            if (left_q == CW'(1)) st_q   <= CH_IDLE;
            else                  left_q <= left_q - 1'b1;
          end
          default: st_q <= CH_IDLE;
        endcase
      end
    end
  end

  // window closing cuts the pulse in the same cycle
  assign en_o = (st_q == CH_FIRING) && armed_i;
endmodule

// File: rtl/arm_fire_seq.sv
module arm_fire_seq #(
  parameter int unsigned CLK_PER_MS = 50000,
  parameter int unsigned ARM_MS     = 10000,
  parameter int unsigned PULSE_MS   = 100,
  parameter int unsigned N_FIRE     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_cmd_i,
  input  logic [N_FIRE-1:0] fire_cmd_i,
  input  logic              heat_cmd_i,
  output logic              arm_relay_o,
  output logic [N_FIRE-1:0] fire_en_o,
  output logic              heat_en_o
);
  localparam int unsigned NCMD = N_FIRE + 2;

  logic            ms_tick;
  logic [NCMD-1:0] cmd_filt;
  logic            armed;

  afs_ms_tick #(.CLK_PER_MS(CLK_PER_MS)) u_tick (
    .clk_i, .rst_ni, .tick_o(ms_tick)
  );

  afs_cmd_filter #(.W(NCMD)) u_filt (
    .clk_i, .rst_ni, .tick_i(ms_tick),
    .raw_i({heat_cmd_i, fire_cmd_i, arm_cmd_i}),
    .filt_o(cmd_filt)
  );

  afs_arm_window #(.ARM_MS(ARM_MS)) u_win (
    .clk_i, .rst_ni, .tick_i(ms_tick), .arm_i(cmd_filt[0]), .armed_o(armed)
  );

  for (genvar c = 0; c < N_FIRE; c++) begin : g_ch
    afs_pulse_timer #(.PULSE_MS(PULSE_MS)) u_pulse (
      .clk_i, .rst_ni, .tick_i(ms_tick), .armed_i(armed),
      .req_i(cmd_filt[c+1]), .en_o(fire_en_o[c])
    );
  end

  assign arm_relay_o = armed;
  assign heat_en_o   = armed & cmd_filt[NCMD-1];
endmodule

// File: rtl/afs_checker.sv
module afs_checker #(
  parameter int unsigned N_FIRE = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              arm_relay_o,
  input logic [N_FIRE-1:0] fire_en_o,
  input logic              heat_en_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (!arm_relay_o && fire_en_o == '0 && !heat_en_o)
        else $error("outputs active during reset");
    end
  end

  p_heat_needs_arm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    heat_en_o |-> arm_relay_o);

  p_open_no_fire_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(arm_relay_o) |-> (fire_en_o == '0));

  p_expiry_all_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(arm_relay_o) |-> (fire_en_o == '0 && !heat_en_o));

  for (genvar c = 0; c < N_FIRE; c++) begin : g_c
    p_fire_needs_arm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_en_o[c] |-> arm_relay_o);

    p_pulse_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(fire_en_o[c]) |-> ($past(tick_i) || $fell(arm_relay_o)));
  end
endmodule

bind arm_fire_seq afs_checker #(.N_FIRE(N_FIRE)) u_afs_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(ms_tick),
  .arm_relay_o(arm_relay_o), .fire_en_o(fire_en_o), .heat_en_o(heat_en_o)
);

// File: tb/tb_arm_fire_seq.sv
`timescale 1ns/1ps
module tb_arm_fire_seq;
  localparam int unsigned CLK_PER_MS = 8;
  localparam int unsigned ARM_MS     = 40;
  localparam int unsigned PULSE_MS   = 8;
  localparam int unsigned N_FIRE     = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0, heat = 1'b0;
  logic [N_FIRE-1:0] fire = '0;
  logic relay, heat_en;
  logic [N_FIRE-1:0] fire_en;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  arm_fire_seq #(.CLK_PER_MS(CLK_PER_MS), .ARM_MS(ARM_MS), .PULSE_MS(PULSE_MS),
                 .N_FIRE(N_FIRE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .arm_cmd_i(arm), .fire_cmd_i(fire),
    .heat_cmd_i(heat), .arm_relay_o(relay), .fire_en_o(fire_en), .heat_en_o(heat_en)
  );

  task automatic wait_ms(input int n);
    repeat (n * CLK_PER_MS) @(negedge clk);
  endtask

  task automatic chk(input logic got, input logic exp, input string tag, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %b expected %b at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic idle_out();
    arm = 1'b0; heat = 1'b0; fire = '0;
    wait_ms(ARM_MS + 4);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset holds outputs low
    repeat (6) @(negedge clk);
    chk(relay, 1'b0, "R1", "relay in reset");
    chk(|fire_en, 1'b0, "R1", "fire in reset");
    chk(heat_en, 1'b0, "R1", "heat in reset");
    rst_n = 1'b1;
    wait_ms(3);
    chk(relay, 1'b0, "R1", "relay after reset");

    // R2: sub-tick glitch rejected on arm
    arm = 1'b1; repeat (CLK_PER_MS / 2) @(negedge clk); arm = 1'b0;
    wait_ms(3);
    chk(relay, 1'b0, "R2", "arm glitch");

    // R4: fire outside window ignored
    fire[0] = 1'b1; wait_ms(3);
    chk(fire_en[0], 1'b0, "R4", "fire unarmed");
    fire[0] = 1'b0; wait_ms(3);

    // R3 R11: window length with arm held high
    arm = 1'b1; wait_ms(3);
    chk(relay, 1'b1, "R3", "window open");
    wait_ms(ARM_MS - 4);
    chk(relay, 1'b1, "R11", "window still open near end");
    wait_ms(4);
    chk(relay, 1'b0, "R3", "window closed, arm held");
    idle_out();

    // R5 R2: per-channel pulse sweep with command held, plus fire glitch
    for (int c = 0; c < N_FIRE; c++) begin
      arm = 1'b1; wait_ms(3);
      fire[c] = 1'b1; repeat (CLK_PER_MS / 2) @(negedge clk); fire[c] = 1'b0;
      wait_ms(3);
      chk(fire_en[c], 1'b0, "R2", "fire glitch");
      fire[c] = 1'b1; wait_ms(3);
      chk(fire_en[c], 1'b1, "R5", "pulse started");
      chk(|(fire_en & ~(N_FIRE'(1) << c)), 1'b0, "R6", "other channels quiet");
      wait_ms(PULSE_MS - 4);
      chk(fire_en[c], 1'b1, "R5", "pulse near end");
      wait_ms(4);
      chk(fire_en[c], 1'b0, "R5", "pulse ended, cmd held");
      idle_out();
    end

    // R6: overlapping independent pulses
    arm = 1'b1; wait_ms(3);
    fire[0] = 1'b1; wait_ms(4);
    fire[1] = 1'b1;
    wait_ms(PULSE_MS - 1);
    chk(fire_en[0], 1'b0, "R6", "ch0 ended");
    chk(fire_en[1], 1'b1, "R6", "ch1 still on");
    idle_out();

    // R10: fire held before window opens
    fire[1] = 1'b1; wait_ms(3);
    arm = 1'b1; wait_ms(4);
    chk(relay, 1'b1, "R10", "window open");
    chk(fire_en[1], 1'b0, "R10", "pre-held fire");
    fire[1] = 1'b0; wait_ms(3);
    fire[1] = 1'b1; wait_ms(3);
    chk(fire_en[1], 1'b1, "R10", "fresh edge fires");
    idle_out();

    // R10: arm and fire rise together
    arm = 1'b1; fire[2] = 1'b1; wait_ms(4);
    chk(relay, 1'b1, "R10", "window open, simultaneous");
    chk(fire_en[2], 1'b0, "R10", "simultaneous fire ignored");
    idle_out();

    // R8: heater follows level
    arm = 1'b1; wait_ms(3);
    heat = 1'b1; wait_ms(3);
    chk(heat_en, 1'b1, "R8", "heater on");
    wait_ms(PULSE_MS + 3);
    chk(heat_en, 1'b1, "R8", "heater past pulse length");
    heat = 1'b0; wait_ms(3);
    chk(heat_en, 1'b0, "R8", "heater off");
    idle_out();

    // R9: expiry during pulse and heater
    arm = 1'b1; wait_ms(3);
    heat = 1'b1; wait_ms(ARM_MS - 9);
    fire[0] = 1'b1; wait_ms(3);
    chk(fire_en[0], 1'b1, "R9", "late pulse running");
    chk(heat_en, 1'b1, "R9", "heater running");
    wait_ms(6);
    chk(relay, 1'b0, "R9", "relay expired");
    chk(fire_en[0], 1'b0, "R9", "pulse cut");
    chk(heat_en, 1'b0, "R9", "heater cut");
    idle_out();

    // R7: restart window by drop and re-raise
    arm = 1'b1; wait_ms(ARM_MS - 8);
    arm = 1'b0; wait_ms(3);
    chk(relay, 1'b1, "R7", "drop does not close");
    arm = 1'b1; wait_ms(ARM_MS - 1);
    chk(relay, 1'b1, "R7", "restarted window open");
    wait_ms(4);
    chk(relay, 1'b0, "R7", "restarted window closed");
    idle_out();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule